// File: doc/BRIEF.md
# Circular Autobuffer with Half and Wrap Interrupts

This block moves serial packets between a framed line interface and a local packet memory without any CPU action per word. A receive engine stores each arriving packet at the next slot of a circular region. A transmit engine fetches the next packet for the serializer from a second circular region. Software gives each region a base address and a length, then arms the engine by writing a starting offset, which is normally zero.

Each engine raises a one-cycle interrupt at two points. The first is when the packet in the middle slot of the region has been handled. The second is when the packet in the last slot has been handled, after which the pointer returns to the start of the region. A flag per direction shows which half of its region the engine is currently working in. With a region of two T1 frames (48 slots) or two E1 frames (64 slots), the CPU can therefore process one complete frame while the engine fills or drains the other. Both pulses also set bits in a sticky cause register, which software clears by writing ones.

The CPU reaches the packet memory through its own port, which has a read latency of one cycle.

Top module: `circ_autobuf`

## Requirements
- R1: After a synchronous reset, both engines are disarmed. `rx_irq`, `tx_irq`, `tx_valid`, `rx_half`, `tx_half` and all four bits of `irq_cause` are 0.
- R2: While the receive engine is armed, each cycle with `rx_valid` high writes `rx_data` to address (base + pointer) modulo the memory depth and advances the pointer. The CPU port returns any location's content one cycle after it samples the address.
- R3: The pointer of either engine stays below the region length. After the slot at offset length-1 has been handled, the next access goes to offset 0.
- R4: Handling the receive slot at offset floor(length/2)-1 makes `rx_irq` high for exactly the following cycle and sets `irq_cause` bit 0.
- R5: Handling the receive slot at offset length-1 makes `rx_irq` high for the following cycle and sets `irq_cause` bit 1.
- R6: `rx_half` and `tx_half` are 1 exactly while the armed engine's pointer is at or above floor(length/2). They change in the same cycle as the matching interrupt.
- R7: While the transmit engine is armed, `tx_req` fetches memory at (base + pointer). In the following cycle `tx_data` holds that value and `tx_valid` is 1. The pointer, `tx_irq` and `tx_half` follow R3, R4, R5 and R6, with `irq_cause` bit 2 set at the half point and bit 3 set at the wrap point.
- R8: Configuration writes use `cfg_addr` as follows: 0 = receive base, 1 = receive length, 2 = receive start, 3 = transmit base, 4 = transmit length, 5 = transmit start, 6 = cause clear. A start write loads the pointer with `cfg_wdata` and arms the engine.
- R9: A start write with a length below 2, or with an offset not below the length, leaves the engine idle. An idle engine stores nothing, raises no interrupt and keeps `tx_valid` low.
- R10: Writing address 6 clears each `irq_cause` bit whose `cfg_wdata` bit is 1. If a new event sets a bit in the same cycle, the bit stays set.
- R11: Writing the base or the length of a direction disarms that engine until its next start write.
- R12: A CPU memory write in the same cycle as a receive store is dropped, and the receive store takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select (see R8) |
| cfg_wdata | input | AW+1 | Configuration write data |
| rx_valid | input | 1 | A received packet is present |
| rx_data | input | DW | Received packet |
| tx_req | input | 1 | Serializer requests the next packet |
| tx_data | output | DW | Fetched transmit packet |
| tx_valid | output | 1 | `tx_data` was fetched in the previous cycle |
| cpu_mem_we | input | 1 | CPU memory write strobe |
| cpu_mem_addr | input | AW | CPU memory address |
| cpu_mem_wdata | input | DW | CPU memory write data |
| cpu_mem_rdata | output | DW | CPU memory read data, one cycle after the address |
| rx_irq | output | 1 | Receive half or wrap pulse |
| tx_irq | output | 1 | Transmit half or wrap pulse |
| rx_half | output | 1 | Receive engine is in the upper half |
| tx_half | output | 1 | Transmit engine is in the upper half |
| irq_cause | output | 4 | Sticky causes: bit 0 receive half, bit 1 receive wrap, bit 2 transmit half, bit 3 transmit wrap |

## Verification
Every result of this block is due one cycle after the stimulus that causes it. A store or fetch sampled at a clock edge produces `rx_irq`/`tx_irq`, the updated half flag, the updated cause bits and, on transmit, `tx_data` with `tx_valid`, right after that same edge. A CPU read returns its data after the edge that samples its address. The bench therefore drives each stimulus at a falling edge, lets one rising edge pass and compares all outputs at the next falling edge against a pointer, cause and memory model computed from the requirements. Each stimulus is held for exactly one cycle, so every interrupt pulse is checked in the single cycle in which it must be high.

// File: rtl/circ_autobuf_pkg.sv
package circ_autobuf_pkg;

  localparam int NDIR = 2;  // index 0: receive, index 1: transmit

  typedef enum logic [2:0] {
    CFG_RX_BASE   = 3'd0,
    CFG_RX_SIZE   = 3'd1,
    CFG_RX_START  = 3'd2,
    CFG_TX_BASE   = 3'd3,
    CFG_TX_SIZE   = 3'd4,
    CFG_TX_START  = 3'd5,
    CFG_CAUSE_CLR = 3'd6
  } cfg_sel_e;

  typedef struct packed {
    logic half;
    logic full;
  } ring_evt_t;

endpackage

// File: rtl/abuf_store.sv
module abuf_store #(
  parameter int DW = 8,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_a_addr,
  output logic [DW-1:0] rd_a_data,
  input  logic          rd_b_en,
  input  logic [AW-1:0] rd_b_addr,
  output logic [DW-1:0] rd_b_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    rd_a_data <= mem[rd_a_addr];
  end

  always_ff @(posedge clk) begin
    if (rd_b_en) rd_b_data <= mem[rd_b_addr];
  end

endmodule

// File: rtl/abuf_cfg_bank.sv
module abuf_cfg_bank
  import circ_autobuf_pkg::*;
#(
  parameter int AW = 7,
  parameter int LW = AW + 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_we,
  input  logic [2:0]                 cfg_addr,
  input  logic [LW-1:0]              cfg_wdata,
  input  ring_evt_t [NDIR-1:0]       evt,
  output logic [NDIR-1:0][AW-1:0]    base_q,
  output logic [NDIR-1:0][LW-1:0]    size_q,
  output logic [NDIR-1:0]            start_wr,
  output logic [NDIR-1:0]            disarm,
  output logic [2*NDIR-1:0]          cause_q
);
  localparam int CW = 2 * NDIR;

  logic          clr_hit;
  logic [CW-1:0] set_bits;
  logic [CW-1:0] clr_bits;

  genvar d;
  generate
    for (d = 0; d < NDIR; d++) begin : g_dir
      localparam cfg_sel_e SEL_BASE  = (d == 0) ? CFG_RX_BASE  : CFG_TX_BASE;
      localparam cfg_sel_e SEL_SIZE  = (d == 0) ? CFG_RX_SIZE  : CFG_TX_SIZE;
      localparam cfg_sel_e SEL_START = (d == 0) ? CFG_RX_START : CFG_TX_START;

      logic          hit_base, hit_size, hit_start;
      logic [AW-1:0] base_r;
      logic [LW-1:0] size_r;

      assign hit_base  = cfg_we && (cfg_addr == SEL_BASE);
      assign hit_size  = cfg_we && (cfg_addr == SEL_SIZE);
      assign hit_start = cfg_we && (cfg_addr == SEL_START);

      always_ff @(posedge clk) begin
        if (rst) begin
          base_r <= '0;
          size_r <= '0;
        end else begin
          if (hit_base) base_r <= cfg_wdata[AW-1:0];
          if (hit_size) size_r <= cfg_wdata;
        end
      end

      assign base_q[d]       = base_r;
      assign size_q[d]       = size_r;
      assign start_wr[d]     = hit_start;
      assign disarm[d]       = hit_base || hit_size;
      assign set_bits[2*d]   = evt[d].half;
      assign set_bits[2*d+1] = evt[d].full;
    end
  endgenerate

  assign clr_hit  = cfg_we && (cfg_addr == CFG_CAUSE_CLR);
  assign clr_bits = clr_hit ? cfg_wdata[CW-1:0] : '0;

  // A new event wins over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) cause_q <= '0;
    else     cause_q <= (cause_q & ~clr_bits) | set_bits;
  end

endmodule

// File: rtl/abuf_ring.sv
module abuf_ring
  import circ_autobuf_pkg::*;
#(
  parameter int AW = 7,
  parameter int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] base_q,
  input  logic [LW-1:0] size_q,
  input  logic          start_wr,
  input  logic [LW-1:0] start_val,
  input  logic          disarm,
  input  logic          step,
  output logic [AW-1:0] addr,
  output ring_evt_t     evt,
  output logic          fire,
  output logic          armed,
  output logic          half_sel,
  output logic          irq
);
  logic [LW-1:0] ptr;
  logic [LW-1:0] half_pt;
  logic [LW-1:0] last_pt;
  logic          start_ok;

  assign half_pt  = size_q >> 1;
  assign last_pt  = size_q - 1'b1;
  assign start_ok = (size_q >= LW'(2)) && (start_val < size_q);

  // A configuration write takes precedence over a data step.
  assign fire     = step && armed && !start_wr && !disarm;
  assign evt.half = fire && (ptr == half_pt - 1'b1);
  assign evt.full = fire && (ptr == last_pt);
  assign addr     = base_q + ptr[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr      <= '0;
      armed    <= 1'b0;
      half_sel <= 1'b0;
      irq      <= 1'b0;
    end else begin
      irq <= evt.half || evt.full;
      if (start_wr) begin
        armed    <= start_ok;
        ptr      <= start_ok ? start_val : '0;
        half_sel <= start_ok && (start_val >= half_pt);
      end else if (disarm) begin
        armed    <= 1'b0;
        ptr      <= '0;
        half_sel <= 1'b0;
      end else if (fire) begin
        if (evt.full) begin
          ptr      <= '0;
          half_sel <= 1'b0;
        end else begin
          ptr <= ptr + 1'b1;
          if (evt.half) half_sel <= 1'b1;
        end
      end
    end
  end

  assert_ptr_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    armed |-> (ptr < size_q));

  assert_irq_needs_arm_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(armed));

  assert_reject_small_R9: assert property (@(posedge clk) disable iff (rst)
    (start_wr && (size_q < LW'(2))) |=> !armed);

  assert_half_flag_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(armed) && !$past(start_wr) && $rose(half_sel)) |-> irq);

endmodule

// File: rtl/circ_autobuf.sv
module circ_autobuf
  import circ_autobuf_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [AW:0]   cfg_wdata,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          tx_req,
  output logic [DW-1:0] tx_data,
  output logic          tx_valid,
  input  logic          cpu_mem_we,
  input  logic [AW-1:0] cpu_mem_addr,
  input  logic [DW-1:0] cpu_mem_wdata,
  output logic [DW-1:0] cpu_mem_rdata,
  output logic          rx_irq,
  output logic          tx_irq,
  output logic          rx_half,
  output logic          tx_half,
  output logic [3:0]    irq_cause
);
  localparam int LW = AW + 1;
  localparam int RX = 0;
  localparam int TX = 1;

  logic [NDIR-1:0][AW-1:0] base_q;
  logic [NDIR-1:0][LW-1:0] size_q;
  logic [NDIR-1:0]         start_wr, disarm;
  logic [NDIR-1:0][AW-1:0] r_addr;
  ring_evt_t [NDIR-1:0]    r_evt;
  logic [NDIR-1:0]         r_fire, r_armed, r_half, r_irq;
  logic [NDIR-1:0]         step;
  logic                    mem_we;
  logic [AW-1:0]           mem_waddr;
  logic [DW-1:0]           mem_wdata;

  assign step = {tx_req, rx_valid};

  abuf_cfg_bank #(.AW(AW), .LW(LW)) u_cfg (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .evt(r_evt),
    .base_q(base_q), .size_q(size_q),
    .start_wr(start_wr), .disarm(disarm),
    .cause_q(irq_cause)
  );

  genvar d;
  generate
    for (d = 0; d < NDIR; d++) begin : g_ring
      abuf_ring #(.AW(AW), .LW(LW)) u_ring (
        .clk(clk), .rst(rst),
        .base_q(base_q[d]), .size_q(size_q[d]),
        .start_wr(start_wr[d]), .start_val(cfg_wdata), .disarm(disarm[d]),
        .step(step[d]),
        .addr(r_addr[d]), .evt(r_evt[d]), .fire(r_fire[d]),
        .armed(r_armed[d]), .half_sel(r_half[d]), .irq(r_irq[d])
      );
    end
  endgenerate

  // The receive engine owns the write port whenever it stores.
  assign mem_we    = r_fire[RX] || cpu_mem_we;
  assign mem_waddr = r_fire[RX] ? r_addr[RX] : cpu_mem_addr;
  assign mem_wdata = r_fire[RX] ? rx_data : cpu_mem_wdata;

  abuf_store #(.DW(DW), .AW(AW)) u_store (
    .clk(clk),
    .wr_en(mem_we), .wr_addr(mem_waddr), .wr_data(mem_wdata),
    .rd_a_addr(cpu_mem_addr), .rd_a_data(cpu_mem_rdata),
    .rd_b_en(r_fire[TX]), .rd_b_addr(r_addr[TX]), .rd_b_data(tx_data)
  );

  always_ff @(posedge clk) begin
    if (rst) tx_valid <= 1'b0;
    else     tx_valid <= r_fire[TX];
  end

  assign rx_irq  = r_irq[RX];
  assign tx_irq  = r_irq[TX];
  assign rx_half = r_half[RX];
  assign tx_half = r_half[TX];

  assert_tx_valid_follows_req_R7: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(tx_req));

  assert_rx_half_cause_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_cause[0]) |-> rx_irq);

  assert_rx_full_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_cause[1]) |-> rx_irq);

  assert_tx_cause_R7: assert property (@(posedge clk) disable iff (rst)
    ($rose(irq_cause[2]) || $rose(irq_cause[3])) |-> tx_irq);

  assert_cause_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && (cfg_addr == CFG_CAUSE_CLR) && cfg_wdata[0] && !r_evt[RX].half)
      |=> !irq_cause[0]);

endmodule

// File: tb/circ_autobuf_test.sv
module circ_autobuf_test;
  localparam int DW = 8;
  localparam int AW = 7;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [AW:0]   cfg_wdata = '0;
  logic          rx_valid = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic          tx_req = 1'b0;
  logic          cpu_mem_we = 1'b0;
  logic [AW-1:0] cpu_mem_addr = '0;
  logic [DW-1:0] cpu_mem_wdata = '0;
  logic [DW-1:0] tx_data, cpu_mem_rdata;
  logic          tx_valid, rx_irq, tx_irq, rx_half, tx_half;
  logic [3:0]    irq_cause;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_mem [DEPTH];
  int  arm_m [2];
  int  ptr_m [2];
  int  size_m [2];
  int  base_m [2];
  logic [3:0] cause_m = '0;
  logic [3:0] pend_clr = '0;

  circ_autobuf #(.DW(DW), .AW(AW)) uut (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_req(tx_req), .tx_data(tx_data), .tx_valid(tx_valid),
    .cpu_mem_we(cpu_mem_we), .cpu_mem_addr(cpu_mem_addr),
    .cpu_mem_wdata(cpu_mem_wdata), .cpu_mem_rdata(cpu_mem_rdata),
    .rx_irq(rx_irq), .tx_irq(tx_irq), .rx_half(rx_half), .tx_half(tx_half),
    .irq_cause(irq_cause)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int half_exp(input int d);
    return (arm_m[d] != 0 && ptr_m[d] >= size_m[d] / 2) ? 1 : 0;
  endfunction

  // Configuration write; called right after a falling edge.
  task automatic cfgw(input int a, input int v);
    int d;
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = (AW+1)'(v);
    @(negedge clk);
    cfg_we = 1'b0;
    d = (a >= 3) ? 1 : 0;
    if (a == 0 || a == 3) begin
      base_m[d] = v % DEPTH; arm_m[d] = 0; ptr_m[d] = 0;
    end else if (a == 1 || a == 4) begin
      size_m[d] = v; arm_m[d] = 0; ptr_m[d] = 0;
    end else if (a == 2 || a == 5) begin
      arm_m[d] = (size_m[d] >= 2 && v < size_m[d]) ? 1 : 0;
      ptr_m[d] = arm_m[d] != 0 ? v : 0;
    end else if (a == 6) begin
      cause_m = cause_m & ~4'(v);
    end
    if (a < 6) chk((d ? tx_half : rx_half) == half_exp(d), "R8 R11 half flag after config",
                   int'(d ? tx_half : rx_half), half_exp(d));
    else chk(irq_cause == cause_m, "R10 cause clear", int'(irq_cause), int'(cause_m));
  endtask

  // One receive store (d=0) or transmit fetch (d=1).
  task automatic op(input int d, input logic [7:0] v);
    int h, a, hv, fv, arm;
    logic [3:0] setb;
    h   = size_m[d] / 2;
    arm = arm_m[d];
    hv  = (arm != 0 && ptr_m[d] == h - 1) ? 1 : 0;
    fv  = (arm != 0 && ptr_m[d] == size_m[d] - 1) ? 1 : 0;
    a   = (base_m[d] + ptr_m[d]) % DEPTH;
    if (d == 0) begin rx_valid = 1'b1; rx_data = v; end
    else tx_req = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; tx_req = 1'b0;
    if (d == 0) begin
      if (arm != 0) exp_mem[a] = v;
      chk(rx_irq == (hv | fv), "R4 R5 rx irq pulse", int'(rx_irq), hv | fv);
    end else begin
      chk(tx_valid == arm, arm != 0 ? "R7 tx valid" : "R9 tx idle", int'(tx_valid), arm);
      if (arm != 0) chk(tx_data == exp_mem[a], "R7 tx data", int'(tx_data), int'(exp_mem[a]));
      chk(tx_irq == (hv | fv), "R7 tx irq pulse", int'(tx_irq), hv | fv);
    end
    if (arm != 0) ptr_m[d] = (fv != 0) ? 0 : ptr_m[d] + 1;
    setb = (d == 0) ? {2'b00, 1'(fv), 1'(hv)} : {1'(fv), 1'(hv), 2'b00};
    cause_m = (cause_m & ~pend_clr) | setb;
    pend_clr = '0;
    chk((d ? tx_half : rx_half) == half_exp(d), "R6 half flag",
        int'(d ? tx_half : rx_half), half_exp(d));
    chk(irq_cause == cause_m, "R4 R5 R7 R10 cause", int'(irq_cause), int'(cause_m));
  endtask

  task automatic cpuw(input int a, input logic [7:0] v);
    cpu_mem_we = 1'b1; cpu_mem_addr = AW'(a); cpu_mem_wdata = v;
    @(negedge clk);
    cpu_mem_we = 1'b0;
    exp_mem[a] = v;
  endtask

  task automatic cpur(input int a, input string req);
    cpu_mem_addr = AW'(a);
    @(negedge clk);
    chk(cpu_mem_rdata == exp_mem[a], req, int'(cpu_mem_rdata), int'(exp_mem[a]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      arm_m[i] = 0; ptr_m[i] = 0; size_m[i] = 0; base_m[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(rx_irq == 1'b0, "R1 rx_irq", int'(rx_irq), 0);
    chk(tx_irq == 1'b0, "R1 tx_irq", int'(tx_irq), 0);
    chk(tx_valid == 1'b0, "R1 tx_valid", int'(tx_valid), 0);
    chk(rx_half == 1'b0 && tx_half == 1'b0, "R1 half flags", int'({rx_half, tx_half}), 0);
    chk(irq_cause == 4'd0, "R1 cause", int'(irq_cause), 0);
    op(0, 8'h11);
    op(1, 8'h00);

    // R2 R3 R4 R5 R6: receive sweep over lengths, odd lengths wrap past memory end
    for (int s = 2; s <= 12; s++) begin
      int b;
      b = (s % 2 != 0) ? DEPTH - 3 : s * 9;
      cfgw(0, b); cfgw(1, s); cfgw(2, 0);
      for (int i = 0; i < 2 * s + 1; i++) op(0, 8'((s * 16 + i * 3) & 255));
      for (int o = 0; o < s; o++) cpur((b + o) % DEPTH, "R2 R3 readback");
      cfgw(6, 15);
    end

    // R8: every legal start offset of a 7-slot region
    cfgw(0, 40); cfgw(1, 7);
    for (int off = 0; off < 7; off++) begin
      cfgw(2, off);
      for (int i = 0; i < 8; i++) op(0, 8'(off * 8 + i));
      cfgw(6, 15);
    end

    // R7: transmit sweep with nonzero start offsets
    for (int s = 2; s <= 12; s++) begin
      int b;
      b = 60 + s;
      for (int o = 0; o < s; o++) cpuw(b + o, 8'((o * 29 + s) & 255));
      cfgw(3, b); cfgw(4, s); cfgw(5, s / 3);
      for (int i = 0; i < 2 * s + 1; i++) op(1, 8'h00);
      cfgw(6, 15);
    end

    // R9: rejected configurations stay idle
    cpuw(10, 8'h3C);
    cfgw(0, 10); cfgw(1, 1); cfgw(2, 0);
    for (int i = 0; i < 3; i++) op(0, 8'hC3);
    cpur(10, "R9 no store len 1");
    cfgw(1, 0); cfgw(2, 0); op(0, 8'hC4);
    cfgw(1, 5); cfgw(2, 5); op(0, 8'hC5);
    cpur(10, "R9 no store bad offset");
    cfgw(4, 1); cfgw(5, 0); op(1, 8'h00);

    // R11: base or length writes disarm
    cfgw(1, 4); cfgw(2, 0); op(0, 8'h01);
    cfgw(0, 10); op(0, 8'h02);
    cpur(10, "R11 base write disarms");
    cfgw(2, 0); cfgw(1, 4); op(0, 8'h03);
    cpur(10, "R11 length write disarms");
    cfgw(6, 15);

    // R10: event wins over a simultaneous clear
    cfgw(1, 2); cfgw(2, 0);
    cfg_we = 1'b1; cfg_addr = 3'd6; cfg_wdata = 8'h0F; pend_clr = 4'hF;
    op(0, 8'h05);
    cfg_we = 1'b0;
    cfgw(6, 1);

    // R12: CPU write colliding with a receive store is dropped
    cpuw(100, 8'h55);
    cfgw(0, 20); cfgw(1, 4); cfgw(2, 0);
    cpu_mem_we = 1'b1; cpu_mem_addr = 7'd100; cpu_mem_wdata = 8'hAA;
    op(0, 8'h77);
    cpu_mem_we = 1'b0;
    cpur(100, "R12 cpu write dropped");
    cpur(20, "R12 rx store kept");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule